// File: doc/BRIEF.md
# Dual FIFO Trigger and Flush Controller

This block sits between a two-wire serial controller and the system side of a chip. It holds two byte queues: a transmit queue that the host side fills and a bit engine drains, and a receive queue that a bit engine fills and the host side drains. One 32-bit control register configures both queues. Either queue can be handed at run time to the master engine or to the slave engine. Strobes from the engine that does not hold the queue are ignored.

Each queue has a programmable fill-level trigger, and that trigger can be turned into a DMA request by a per-direction enable. Each queue also has a flush bit. Writing 1 to it empties the queue. The bit reads back as 1 while the flush is in progress and clears itself once the queue is empty. Both queues report their fill level, full and empty flags, and a sticky error flag for strobes that had to be dropped.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00040004, both queues are empty with level 0, and every error flag and DMA request is 0.
- R2: Control fields sit at these positions. RX side: owner at bit 31, flush at bit 30, DMA enable at bit 29, trigger level at bits 18:16. TX side: owner at bit 15, flush at bit 14, DMA enable at bit 13, trigger level at bits 2:0. Every other bit reads 0 and ignores writes.
- R3: An owner bit of 0 gives the queue to the master engine and 1 gives it to the slave engine. A strobe from the engine that does not own the queue changes neither its level, its head byte nor its error flag.
- R4: Each queue holds 8 bytes in arrival order. The head byte is shown on the head output before it is popped. The level runs from 0 to 8, `full` is high at 8 and `empty` is high at 0.
- R5: `rx_trig` is 1 when the RX level is greater than or equal to the RX trigger field, except that a field value of 0 never raises it.
- R6: `tx_trig` is 1 when the TX level is less than or equal to the TX trigger field.
- R7: A DMA request output is 1 exactly when that direction's DMA enable bit is 1 and its trigger is 1.
- R8: Writing 1 to a flush bit makes that bit read 1 for exactly the next cycle. At the end of that cycle the queue is empty. Push and pop strobes in that cycle are ignored and raise no error.
- R9: A push to a full queue and a pop from an empty queue are dropped. Either one sets that queue's error flag, which stays set until reset.
- R10: A change of owner leaves the queue contents unchanged. During the cycle that carries the register write, strobes are judged against the old owner; from the next cycle on, against the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| tx_host_wr | input | 1 | Host push into TX queue |
| tx_host_data | input | 8 | Byte pushed into TX queue |
| tx_mst_rd | input | 1 | Master engine pop from TX queue |
| tx_slv_rd | input | 1 | Slave engine pop from TX queue |
| tx_head | output | 8 | Oldest TX byte |
| tx_level | output | 4 | TX fill level |
| tx_full | output | 1 | TX queue full |
| tx_empty | output | 1 | TX queue empty |
| tx_err | output | 1 | Sticky TX drop flag |
| tx_trig | output | 1 | TX fill trigger |
| tx_dma_req | output | 1 | TX DMA request |
| rx_mst_wr | input | 1 | Master engine push into RX queue |
| rx_mst_data | input | 8 | Master engine RX byte |
| rx_slv_wr | input | 1 | Slave engine push into RX queue |
| rx_slv_data | input | 8 | Slave engine RX byte |
| rx_host_rd | input | 1 | Host pop from RX queue |
| rx_head | output | 8 | Oldest RX byte |
| rx_level | output | 4 | RX fill level |
| rx_full | output | 1 | RX queue full |
| rx_empty | output | 1 | RX queue empty |
| rx_err | output | 1 | Sticky RX drop flag |
| rx_trig | output | 1 | RX fill trigger |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The assertions take for granted that every strobe is a clean single-cycle level sampled at the clock edge. The non-owner check further assumes that no host strobe on the same queue coincides with the engine strobe it watches. The flush checks assume the register is written at most once per flush, so a new flush never overlaps one already pending. The stimulus respects all of this: it drives each strobe for one cycle from the falling edge, never touches a queue from the host side while probing ownership, and always lets a flush finish before the next register write.

// File: rtl/ftc_pkg.sv
// Package for the dual FIFO trigger controller.
// Holds the per-direction control field type and the bit positions of the
// control register fields that the read and write paths decode.
package ftc_pkg;

    localparam int TRIG_W = 3;

    // Per-direction control fields
    typedef struct packed {
        logic              owner;   // 0 master engine, 1 slave engine
        logic              flush;   // self-clearing flush request
        logic              dma_en;  // DMA request enable
        logic [TRIG_W-1:0] thr;     // fill-level trigger value
    } lane_cfg_t;

    // Field positions: RX half at the top, TX half at the bottom
    localparam int RX_OWN_BIT   = 31;
    localparam int RX_FLUSH_BIT = 30;
    localparam int RX_DMA_BIT   = 29;
    localparam int RX_THR_LSB   = 16;
    localparam int TX_OWN_BIT   = 15;
    localparam int TX_FLUSH_BIT = 14;
    localparam int TX_DMA_BIT   = 13;
    localparam int TX_THR_LSB   = 0;

    localparam logic [TRIG_W-1:0] THR_RESET = TRIG_W'(4);

endpackage

// File: rtl/ftc_byte_fifo.sv
// Byte queue with a one-cycle synchronous flush.
// Shows the oldest entry on rdata_o before it is popped. A push when full or
// a pop when empty is dropped and sets a sticky error flag. During a flush
// cycle every strobe is ignored. Assumes DEPTH >= 2.
module ftc_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             push_ok, pop_ok, drop;

    assign full_o  = (count == LVL_W'(DEPTH));
    assign empty_o = (count == '0);
    assign level_o = count;
    assign rdata_o = mem[rd_ptr];

    // Qualify strobes against the fill state and the flush cycle
    always_comb begin
        push_ok = push_i && !full_o && !flush_i;
        pop_ok  = pop_i && !empty_o && !flush_i;
        drop    = !flush_i && ((push_i && full_o) || (pop_i && empty_o));
    end

    // Store the incoming byte at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata_i;
    end

    // Pointer, count and sticky error update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            err_o  <= 1'b0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + LVL_W'(push_ok) - LVL_W'(pop_ok);
            if (drop) err_o <= 1'b1;
        end
    end

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_o == '0));
    assert_overflow_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> (err_o && full_o));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/ftc_lane.sv
// One direction of the controller: ownership steering, queue and trigger.
// IS_RX selects the direction. For RX the owning engine pushes and the host
// pops, and the trigger fires at or above the threshold, never at 0. For TX
// the host pushes and the owning engine pops, and the trigger fires at or
// below the threshold. Assumes owner_i comes straight from a register.
module ftc_lane
    import ftc_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_cfg_t        cfg_i,
    input  logic             host_stb_i,
    input  logic [WIDTH-1:0] host_data_i,
    input  logic             mst_stb_i,
    input  logic [WIDTH-1:0] mst_data_i,
    input  logic             slv_stb_i,
    input  logic [WIDTH-1:0] slv_data_i,
    output logic [WIDTH-1:0] head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o,
    output logic             trig_o,
    output logic             dma_req_o
);

    logic             eng_stb;
    logic [WIDTH-1:0] eng_data;
    logic             push, pop;
    logic [WIDTH-1:0] wdata;
    logic [LVL_W-1:0] thr_ext;

    // Steer strobes and data from the engine that owns this queue
    always_comb begin
        eng_stb  = cfg_i.owner ? slv_stb_i  : mst_stb_i;
        eng_data = cfg_i.owner ? slv_data_i : mst_data_i;
        push     = IS_RX ? eng_stb    : host_stb_i;
        pop      = IS_RX ? host_stb_i : eng_stb;
        wdata    = IS_RX ? eng_data   : host_data_i;
    end

    ftc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (wdata),
        .pop_i   (pop),
        .flush_i (cfg_i.flush),
        .rdata_o (head_o),
        .level_o (level_o),
        .full_o  (full_o),
        .empty_o (empty_o),
        .err_o   (err_o)
    );

    assign thr_ext = LVL_W'(cfg_i.thr);

    generate
        if (IS_RX) begin : g_rx_trig
            // Fill reached the threshold; a zero threshold never fires
            assign trig_o = (cfg_i.thr != '0) && (level_o >= thr_ext);
            assert_zero_thr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i.thr == '0) |-> (!trig_o && !dma_req_o));
        end else begin : g_tx_trig
            // Fill dropped to the threshold or below: ask for more data
            assign trig_o = (level_o <= thr_ext);
        end
    endgenerate

    assign dma_req_o = cfg_i.dma_en && trig_o;

    assert_non_owner_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_stb_i && !cfg_i.flush &&
         ((cfg_i.owner && mst_stb_i && !slv_stb_i) ||
          (!cfg_i.owner && slv_stb_i && !mst_stb_i)))
        |=> ($stable(level_o) && $stable(head_o) && $stable(err_o)));

endmodule

// File: rtl/fifo_trig_ctrl.sv
// Top of the dual FIFO trigger and flush controller.
// Holds the 32-bit control register, clears each flush bit one cycle after it
// is set, and instantiates one TX lane and one RX lane. Reserved register bits
// are not stored. Assumes single-cycle write strobes.
module fifo_trig_ctrl
    import ftc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             tx_host_wr,
    input  logic [WIDTH-1:0] tx_host_data,
    input  logic             tx_mst_rd,
    input  logic             tx_slv_rd,
    output logic [WIDTH-1:0] tx_head,
    output logic [LVL_W-1:0] tx_level,
    output logic             tx_full,
    output logic             tx_empty,
    output logic             tx_err,
    output logic             tx_trig,
    output logic             tx_dma_req,
    input  logic             rx_mst_wr,
    input  logic [WIDTH-1:0] rx_mst_data,
    input  logic             rx_slv_wr,
    input  logic [WIDTH-1:0] rx_slv_data,
    input  logic             rx_host_rd,
    output logic [WIDTH-1:0] rx_head,
    output logic [LVL_W-1:0] rx_level,
    output logic             rx_full,
    output logic             rx_empty,
    output logic             rx_err,
    output logic             rx_trig,
    output logic             rx_dma_req
);

    lane_cfg_t tx_cfg, rx_cfg;

    // Register write; flush bits live for one cycle only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cfg <= '{owner: 1'b0, flush: 1'b0, dma_en: 1'b0, thr: THR_RESET};
            rx_cfg <= '{owner: 1'b0, flush: 1'b0, dma_en: 1'b0, thr: THR_RESET};
        end else begin
            tx_cfg.flush <= cfg_wr && cfg_wdata[TX_FLUSH_BIT];
            rx_cfg.flush <= cfg_wr && cfg_wdata[RX_FLUSH_BIT];
            if (cfg_wr) begin
                tx_cfg.owner  <= cfg_wdata[TX_OWN_BIT];
                tx_cfg.dma_en <= cfg_wdata[TX_DMA_BIT];
                tx_cfg.thr    <= cfg_wdata[TX_THR_LSB +: TRIG_W];
                rx_cfg.owner  <= cfg_wdata[RX_OWN_BIT];
                rx_cfg.dma_en <= cfg_wdata[RX_DMA_BIT];
                rx_cfg.thr    <= cfg_wdata[RX_THR_LSB +: TRIG_W];
            end
        end
    end

    // Assemble the read value; unlisted bits stay zero
    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[TX_OWN_BIT]                 = tx_cfg.owner;
        cfg_rdata[TX_FLUSH_BIT]               = tx_cfg.flush;
        cfg_rdata[TX_DMA_BIT]                 = tx_cfg.dma_en;
        cfg_rdata[TX_THR_LSB +: TRIG_W]       = tx_cfg.thr;
        cfg_rdata[RX_OWN_BIT]                 = rx_cfg.owner;
        cfg_rdata[RX_FLUSH_BIT]               = rx_cfg.flush;
        cfg_rdata[RX_DMA_BIT]                 = rx_cfg.dma_en;
        cfg_rdata[RX_THR_LSB +: TRIG_W]       = rx_cfg.thr;
    end

    ftc_lane #(.IS_RX(1'b0), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (tx_cfg),
        .host_stb_i  (tx_host_wr),
        .host_data_i (tx_host_data),
        .mst_stb_i   (tx_mst_rd),
        .mst_data_i  ('0),
        .slv_stb_i   (tx_slv_rd),
        .slv_data_i  ('0),
        .head_o      (tx_head),
        .level_o     (tx_level),
        .full_o      (tx_full),
        .empty_o     (tx_empty),
        .err_o       (tx_err),
        .trig_o      (tx_trig),
        .dma_req_o   (tx_dma_req)
    );

    ftc_lane #(.IS_RX(1'b1), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (rx_cfg),
        .host_stb_i  (rx_host_rd),
        .host_data_i ('0),
        .mst_stb_i   (rx_mst_wr),
        .mst_data_i  (rx_mst_data),
        .slv_stb_i   (rx_slv_wr),
        .slv_data_i  (rx_slv_data),
        .head_o      (rx_head),
        .level_o     (rx_level),
        .full_o      (rx_full),
        .empty_o     (rx_empty),
        .err_o       (rx_err),
        .trig_o      (rx_trig),
        .dma_req_o   (rx_dma_req)
    );

    assert_tx_flush_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[TX_FLUSH_BIT]) |=> cfg_rdata[TX_FLUSH_BIT]);
    assert_tx_flush_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[TX_FLUSH_BIT] && !cfg_wr) |=> !cfg_rdata[TX_FLUSH_BIT]);
    assert_rx_flush_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[RX_FLUSH_BIT] && !cfg_wr) |=> !cfg_rdata[RX_FLUSH_BIT]);

endmodule

// File: tb/fifo_trig_ctrl_bench.sv
module fifo_trig_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tx_host_wr = 1'b0;
    logic [7:0]  tx_host_data = '0;
    logic        tx_mst_rd = 1'b0, tx_slv_rd = 1'b0;
    logic [7:0]  tx_head;
    logic [3:0]  tx_level;
    logic        tx_full, tx_empty, tx_err, tx_trig, tx_dma_req;
    logic        rx_mst_wr = 1'b0, rx_slv_wr = 1'b0;
    logic [7:0]  rx_mst_data = '0, rx_slv_data = '0;
    logic        rx_host_rd = 1'b0;
    logic [7:0]  rx_head;
    logic [3:0]  rx_level;
    logic        rx_full, rx_empty, rx_err, rx_trig, rx_dma_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_trig_ctrl u_fifo_trig_ctrl (.*);

    // Table entry: [15:12] TX pushes, [11:9] TX threshold, [8] TX trigger
    // expected, [7:4] RX pushes, [3:1] RX threshold, [0] RX trigger expected
    localparam logic [15:0] VEC [8] = '{
        16'h0900, 16'h4949, 16'h5838, 16'h8E8F,
        16'h7F70, 16'h1013, 16'h0126, 16'h3D6D
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        cyc();
        cfg_wr = 1'b0;
    endtask

    task automatic tx_push(input logic [7:0] d);
        tx_host_wr = 1'b1;
        tx_host_data = d;
        cyc();
        tx_host_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        chk("R1 cfg_rdata", cfg_rdata, 32'h0004_0004);
        chk("R1 levels", {tx_level, rx_level}, 8'h00);
        chk("R1 empty", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk("R1 err/dma", {tx_err, rx_err, tx_dma_req, rx_dma_req}, 4'b0000);
        chk("R6 reset tx_trig", tx_trig, 1'b1);
        chk("R5 reset rx_trig", rx_trig, 1'b0);

        // R2: field positions and reserved bits
        wr_cfg(32'h9FFB_9FFB);
        chk("R2 fields", cfg_rdata, 32'h8003_8003);
        wr_cfg(32'h0004_0004);

        // Table walk: R5 R6 R7 for several levels and thresholds
        for (int i = 0; i < 8; i++) begin
            logic [3:0] txn, rxn;
            logic [2:0] txt, rxt;
            txn = VEC[i][15:12]; txt = VEC[i][11:9];
            rxn = VEC[i][7:4];   rxt = VEC[i][3:1];
            wr_cfg(32'h4000_4000);
            cyc();
            wr_cfg(32'h2000_2000 | (32'(rxt) << 16) | 32'(txt));
            for (int k = 0; k < 8; k++) begin
                tx_host_wr = (k < int'(txn));
                tx_host_data = 8'(k);
                rx_mst_wr = (k < int'(rxn));
                rx_mst_data = 8'(k);
                cyc();
            end
            tx_host_wr = 1'b0;
            rx_mst_wr = 1'b0;
            chk("R4 table tx_level", tx_level, txn);
            chk("R4 table rx_level", rx_level, rxn);
            chk("R6 table tx_trig", tx_trig, VEC[i][8]);
            chk("R5 table rx_trig", rx_trig, VEC[i][0]);
            chk("R7 table dma", {tx_dma_req, rx_dma_req}, {VEC[i][8], VEC[i][0]});
        end
        // R7: trigger true but DMA disabled
        wr_cfg(32'h0001_0007);
        chk("R7 dma off", {tx_trig, rx_trig, tx_dma_req, rx_dma_req}, 4'b1100);

        // Prepare: flush both, default config, master owns both
        wr_cfg(32'h4004_4004);
        cyc();
        chk("R8 both flushed", {tx_level, rx_level}, 8'h00);
        tx_push(8'hA1);
        tx_push(8'hA2);
        tx_push(8'hA3);
        chk("R4 head order", tx_head, 8'hA1);
        chk("R4 level 3", tx_level, 4'd3);

        // R3: slave pop while master owns
        tx_slv_rd = 1'b1; cyc(); tx_slv_rd = 1'b0;
        chk("R3 non-owner pop level", tx_level, 4'd3);
        chk("R3 non-owner pop head", tx_head, 8'hA1);
        tx_mst_rd = 1'b1; cyc(); tx_mst_rd = 1'b0;
        chk("R3 owner pop", {tx_level, tx_head}, {4'd2, 8'hA2});

        // R10: owner write cycle still honours the old owner
        tx_mst_rd = 1'b1;
        wr_cfg(32'h0004_8004);
        chk("R10 old owner in write cycle", {tx_level, tx_head}, {4'd1, 8'hA3});
        cyc();
        tx_mst_rd = 1'b0;
        chk("R10 new owner from next cycle", {tx_level, tx_head}, {4'd1, 8'hA3});
        tx_slv_rd = 1'b1; cyc(); tx_slv_rd = 1'b0;
        chk("R3 slave owner pop", tx_level, 4'd0);
        chk("R3 no error from ignored pops", tx_err, 1'b0);

        // R3/R10: RX handed to slave
        wr_cfg(32'h8004_8004);
        rx_mst_wr = 1'b1; rx_mst_data = 8'h11; cyc(); rx_mst_wr = 1'b0;
        chk("R3 rx non-owner push", rx_level, 4'd0);
        rx_slv_wr = 1'b1; rx_slv_data = 8'h5A; cyc(); rx_slv_wr = 1'b0;
        chk("R3 rx owner push", {rx_level, rx_head}, {4'd1, 8'h5A});
        rx_host_rd = 1'b1; cyc(); rx_host_rd = 1'b0;
        chk("R4 rx pop", {rx_level, rx_empty}, {4'd0, 1'b1});

        // R8: flush timing and ignored strobes
        tx_push(8'h01);
        tx_push(8'h02);
        tx_push(8'h03);
        wr_cfg(32'h8004_C004);
        chk("R8 flush bit reads 1", cfg_rdata[14], 1'b1);
        chk("R8 level before flush done", tx_level, 4'd3);
        tx_host_wr = 1'b1; tx_slv_rd = 1'b1;
        cyc();
        tx_host_wr = 1'b0; tx_slv_rd = 1'b0;
        chk("R8 flush bit cleared", cfg_rdata[14], 1'b0);
        chk("R8 tx emptied", {tx_level, tx_empty}, {4'd0, 1'b1});
        chk("R8 no error in flush cycle", tx_err, 1'b0);
        rx_slv_wr = 1'b1; rx_slv_data = 8'h77; cyc(); cyc(); rx_slv_wr = 1'b0;
        wr_cfg(32'hC004_8004);
        chk("R8 rx flush bit", {cfg_rdata[30], rx_level}, {1'b1, 4'd2});
        cyc();
        chk("R8 rx flushed", {cfg_rdata[30], rx_level}, {1'b0, 4'd0});

        // R9: overflow, underflow, stickiness
        for (int k = 0; k < 8; k++) tx_push(8'(8'h40 + k));
        chk("R4 tx full", {tx_full, tx_level, tx_err}, {1'b1, 4'd8, 1'b0});
        tx_push(8'hEE);
        chk("R9 overflow dropped", {tx_level, tx_err}, {4'd8, 1'b1});
        for (int k = 0; k < 8; k++) begin
            chk("R4 drain order", tx_head, 8'(8'h40 + k));
            tx_slv_rd = 1'b1; cyc(); tx_slv_rd = 1'b0;
        end
        chk("R9 error sticky", {tx_err, tx_empty}, 2'b11);
        chk("R9 rx no error yet", rx_err, 1'b0);
        rx_host_rd = 1'b1; cyc(); rx_host_rd = 1'b0;
        chk("R9 underflow", {rx_err, rx_level}, {1'b1, 4'd0});

        finish_run();
    end

endmodule